// File: doc/BRIEF.md
# BCD Calendar Timekeeper with Coherent Snapshot

This block is the counting core of a real-time clock. It holds seconds, minutes, hours, day of month, month, two-digit year and day of week as packed BCD bytes. Each pulse on a 1 Hz tick input advances them when the run bit is set. The calendar follows month lengths and treats every year divisible by four as a leap year inside the 00..99 range. Only 24-hour counting is built.

Software reaches the block through a byte-wide register port with an address, write data, a write strobe and a combinational read. A control byte runs or halts the counters. A control write can also take a snapshot of all seven time bytes into shadow latches. A view bit then steers reads of the time addresses to that frozen copy, so a multi-byte read stays coherent while the live counters keep going. A status byte gathers sticky rollover events and a power-up flag. The same events also appear on four one-cycle output strobes.

Top module: `bcd_timekeeper`

## Requirements
- R1: After reset the time bytes read seconds 0x00, minutes 0x00, hours 0x00, day 0x01, month 0x01, year 0x00, weekday 0x00 at addresses 0x00..0x06 in that order. Control (0x0D) reads 0x00 and status (0x0E) reads 0x80.
- R2: While control bit 0 (run) is 0, ticks change no time byte and raise no event strobe. Status bit 1 always reads the value of control bit 0.
- R3: With run set, each tick advances seconds in BCD from 00 to 59. The carry moves minutes 00..59 and hours 00..23, and the new value is readable in the cycle after the tick cycle.
- R4: The day of month wraps to 01 after 31, 30, 28 or 29 according to the month. February has 29 days when the year value is divisible by 4, year 00 included. Month 12 wraps to 01 and steps the year, and the year wraps from 99 to 00.
- R5: The weekday counts 0..6 and steps once at each midnight rollover, wrapping 6 to 0.
- R6: Event strobes are high for one cycle, in the same cycle the counters show their new value. The second strobe fires on every counted tick, the minute strobe when seconds wrap, the hour strobe when minutes wrap and the day strobe when hours wrap.
- R7: A write to address 0x00..0x06 loads that time byte at the write edge. A tick in the same cycle as such a write is dropped.
- R8: A control write with data bit 6 set copies all seven live time bytes into the shadow at that edge. Control bit 6 always reads back 0.
- R9: When control bit 7 is 1, reads of 0x00..0x06 return the shadow copy, which holds still while the live counters run. When bit 7 is 0, these reads return the live values.
- R10: Status bits 2, 3, 4 and 5 latch the second, minute, hour and day events. Bit 7 is the power-up flag, which reset sets. Writing 1 to any of these bits clears it, and an event in the same cycle wins over the clear. Bits 0 and 6 read 0.
- R11: Control bits 1..5 are stored and read back but do not change counting, so hours still go from 12 to 13. Unmapped addresses read 0x00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_i | input | 1 | One-cycle pulse per elapsed second |
| addr_i | input | ADDR_W | Register address |
| wdata_i | input | 8 | Write data |
| wr_i | input | 1 | Write strobe |
| rdata_o | output | 8 | Read data for addr_i (combinational) |
| ev_sec_o | output | 1 | Counted-second strobe |
| ev_min_o | output | 1 | Minute rollover strobe |
| ev_hour_o | output | 1 | Hour rollover strobe |
| ev_day_o | output | 1 | Day rollover strobe |

## Verification
The hardest states to reach from the ports are the month-end and year-end carries, since they need a whole chain of counters to wrap together. Running real time to get there is far too slow. The bench halts the clock, loads 23:59:59 together with the last or second-to-last day of each month across four consecutive years and year 99, then restarts and sends one tick. The snapshot case is reached by freezing a copy, letting the live counters move on, and reading both views.

// File: rtl/bcd_tk_pkg.sv
package bcd_tk_pkg;

  localparam int NFIELD      = 7;
  localparam int ADDR_CTRL   = 13;
  localparam int ADDR_STAT   = 14;

  localparam int CB_RUN      = 0;
  localparam int CB_SNAP     = 6;
  localparam int CB_VIEW     = 7;
  localparam logic [7:0] CTRL_KEEP = 8'hBF;

  localparam int SB_RUN      = 1;
  localparam int SB_EV_LO    = 2;
  localparam int SB_PWR      = 7;

  // first member is the most significant byte: byte i holds field i
  typedef struct packed {
    logic [7:0] wday;
    logic [7:0] year;
    logic [7:0] mon;
    logic [7:0] day;
    logic [7:0] hour;
    logic [7:0] min;
    logic [7:0] sec;
  } tk_time_t;

  function automatic logic [6:0] bcd2bin(logic [7:0] b);
    return 7'(int'(b[7:4]) * 10 + int'(b[3:0]));
  endfunction

  function automatic logic [7:0] bin2bcd(logic [6:0] v);
    int q;
    int r;
    q = int'(v) / 10;
    r = int'(v) % 10;
    return {4'(q), 4'(r)};
  endfunction

  function automatic logic [6:0] month_days(logic [7:0] mon_bcd, logic [7:0] yr_bcd);
    logic [6:0] m;
    logic [6:0] y;
    m = bcd2bin(mon_bcd);
    y = bcd2bin(yr_bcd);
    case (m)
      7'd2:                       return (y[1:0] == 2'b00) ? 7'd29 : 7'd28;
      7'd4, 7'd6, 7'd9, 7'd11:    return 7'd30;
      default:                    return 7'd31;
    endcase
  endfunction

  // returns {wrapped, next value}; values at or past the top wrap to base
  function automatic logic [8:0] wrap_inc(logic [7:0] cur, logic [6:0] top, logic [6:0] base);
    logic [6:0] b;
    b = bcd2bin(cur);
    if (b >= top) return {1'b1, bin2bcd(base)};
    return {1'b0, bin2bcd(b + 7'd1)};
  endfunction

  function automatic logic [7:0] pick_field(tk_time_t t, logic [2:0] i);
    case (i)
      3'd0:    return t.sec;
      3'd1:    return t.min;
      3'd2:    return t.hour;
      3'd3:    return t.day;
      3'd4:    return t.mon;
      3'd5:    return t.year;
      3'd6:    return t.wday;
      default: return 8'h00;
    endcase
  endfunction

endpackage

// File: rtl/tk_calendar.sv
module tk_calendar
  import bcd_tk_pkg::*;
#(
  parameter int SEC_TOP  = 59,
  parameter int MIN_TOP  = 59,
  parameter int HOUR_TOP = 23,
  parameter int MON_TOP  = 12,
  parameter int YEAR_TOP = 99,
  parameter int WDAY_TOP = 6
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       step_i,
  input  logic       ld_en_i,
  input  logic [2:0] ld_idx_i,
  input  logic [7:0] ld_data_i,
  output tk_time_t   now_o,
  output logic       ev_sec_o,
  output logic       ev_min_o,
  output logic       ev_hour_o,
  output logic       ev_day_o
);

  localparam logic [6:0] SEC_T  = 7'(SEC_TOP);
  localparam logic [6:0] MIN_T  = 7'(MIN_TOP);
  localparam logic [6:0] HOUR_T = 7'(HOUR_TOP);
  localparam logic [6:0] MON_T  = 7'(MON_TOP);
  localparam logic [6:0] YEAR_T = 7'(YEAR_TOP);
  localparam logic [6:0] WDAY_T = 7'(WDAY_TOP);

  tk_time_t t_q;

  logic [7:0] n_sec, n_min, n_hour, n_day, n_mon, n_year, n_wday;
  logic       w_sec, w_min, w_hour, w_day, w_mon, w_year, w_wday;
  logic       carry_min, carry_hour, carry_day, carry_mon, carry_year;
  logic [6:0] day_top;

  always_comb begin
    day_top = month_days(t_q.mon, t_q.year);
    {w_sec,  n_sec}  = wrap_inc(t_q.sec,  SEC_T,  7'd0);
    {w_min,  n_min}  = wrap_inc(t_q.min,  MIN_T,  7'd0);
    {w_hour, n_hour} = wrap_inc(t_q.hour, HOUR_T, 7'd0);
    {w_day,  n_day}  = wrap_inc(t_q.day,  day_top, 7'd1);
    {w_mon,  n_mon}  = wrap_inc(t_q.mon,  MON_T,  7'd1);
    {w_year, n_year} = wrap_inc(t_q.year, YEAR_T, 7'd0);
    {w_wday, n_wday} = wrap_inc(t_q.wday, WDAY_T, 7'd0);
  end

  // ripple of rollovers, each named for the checks below
  assign carry_min  = w_sec;
  assign carry_hour = carry_min  & w_min;
  assign carry_day  = carry_hour & w_hour;
  assign carry_mon  = carry_day  & w_day;
  assign carry_year = carry_mon  & w_mon;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      t_q       <= '{wday: 8'h00, year: 8'h00, mon: 8'h01, day: 8'h01,
                     hour: 8'h00, min: 8'h00, sec: 8'h00};
      ev_sec_o  <= 1'b0;
      ev_min_o  <= 1'b0;
      ev_hour_o <= 1'b0;
      ev_day_o  <= 1'b0;
    end else begin
      ev_sec_o  <= step_i;
      ev_min_o  <= step_i & carry_min;
      ev_hour_o <= step_i & carry_hour;
      ev_day_o  <= step_i & carry_day;
      if (ld_en_i) begin
        case (ld_idx_i)
          3'd0:    t_q.sec  <= ld_data_i;
          3'd1:    t_q.min  <= ld_data_i;
          3'd2:    t_q.hour <= ld_data_i;
          3'd3:    t_q.day  <= ld_data_i;
          3'd4:    t_q.mon  <= ld_data_i;
          3'd5:    t_q.year <= ld_data_i;
          3'd6:    t_q.wday <= ld_data_i;
          default: ;
        endcase
      end else if (step_i) begin
        t_q.sec <= n_sec;
        if (carry_min)  t_q.min  <= n_min;
        if (carry_hour) t_q.hour <= n_hour;
        if (carry_day) begin
          t_q.day  <= n_day;
          t_q.wday <= n_wday;
        end
        if (carry_mon)  t_q.mon  <= n_mon;
        if (carry_year) t_q.year <= n_year;
      end
    end
  end

  assign now_o = t_q;

  assert_min_event_at_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ev_min_o |-> (t_q.sec == 8'h00) && ev_sec_o);

  assert_day_event_midnight_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ev_day_o |-> (t_q.hour == 8'h00) && (t_q.min == 8'h00) && ev_hour_o && ev_min_o);

  assert_day_event_day_valid_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ev_day_o |-> (t_q.day != 8'h00) && (bcd2bin(t_q.day) <= 7'd31));

  assert_idle_holds_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!step_i && !ld_en_i) |=> $stable(t_q));

endmodule

// File: rtl/tk_shadow.sv
module tk_shadow
  import bcd_tk_pkg::*;
#(
  parameter int FIELDS = NFIELD
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     snap_i,
  input  tk_time_t live_i,
  output tk_time_t held_o
);

  localparam int W = 8 * FIELDS;

  logic [W-1:0] live_v;
  logic [W-1:0] held_v;

  assign live_v = live_i;

  for (genvar g = 0; g < FIELDS; g++) begin : g_byte
    always_ff @(posedge clk) begin
      if (!rst_n)      held_v[8*g +: 8] <= 8'h00;
      else if (snap_i) held_v[8*g +: 8] <= live_v[8*g +: 8];
    end
  end

  assign held_o = held_v;

  assert_snap_copies_live_R8: assert property (@(posedge clk) disable iff (!rst_n)
    snap_i |=> (held_o == $past(live_i)));

  assert_shadow_frozen_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !snap_i |=> $stable(held_o));

endmodule

// File: rtl/tk_ctrl_status.sv
module tk_ctrl_status
  import bcd_tk_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_ctrl_i,
  input  logic       wr_stat_i,
  input  logic [7:0] wdata_i,
  input  logic       ev_sec_i,
  input  logic       ev_min_i,
  input  logic       ev_hour_i,
  input  logic       ev_day_i,
  output logic [7:0] ctrl_o,
  output logic [7:0] stat_o,
  output logic       run_o,
  output logic       view_o,
  output logic       snap_o
);

  logic [7:0] ctrl_q;
  logic [3:0] sticky_q;
  logic       pwr_q;
  logic [3:0] ev_vec;
  logic [3:0] clr_vec;

  assign ev_vec  = {ev_day_i, ev_hour_i, ev_min_i, ev_sec_i};
  assign clr_vec = wr_stat_i ? wdata_i[SB_EV_LO +: 4] : 4'b0000;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q   <= 8'h00;
      sticky_q <= 4'b0000;
      pwr_q    <= 1'b1;
    end else begin
      if (wr_ctrl_i) ctrl_q <= wdata_i & CTRL_KEEP;
      sticky_q <= (sticky_q & ~clr_vec) | ev_vec;
      if (wr_stat_i && wdata_i[SB_PWR]) pwr_q <= 1'b0;
    end
  end

  assign run_o  = ctrl_q[CB_RUN];
  assign view_o = ctrl_q[CB_VIEW];
  assign snap_o = wr_ctrl_i & wdata_i[CB_SNAP];
  assign ctrl_o = ctrl_q;
  assign stat_o = {pwr_q, 1'b0, sticky_q, ctrl_q[CB_RUN], 1'b0};

  assert_day_event_sticks_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ev_day_i |=> stat_o[SB_EV_LO + 3]);

  assert_pwr_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stat_i && wdata_i[SB_PWR]) |=> !stat_o[SB_PWR]);

  assert_snap_bit_reads_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ctrl_i |=> !ctrl_o[CB_SNAP]);

endmodule

// File: rtl/bcd_timekeeper.sv
module bcd_timekeeper
  import bcd_tk_pkg::*;
#(
  parameter int ADDR_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [7:0]        wdata_i,
  input  logic              wr_i,
  output logic [7:0]        rdata_o,
  output logic              ev_sec_o,
  output logic              ev_min_o,
  output logic              ev_hour_o,
  output logic              ev_day_o
);

  localparam logic [ADDR_W-1:0] A_TIME_END = ADDR_W'(NFIELD);
  localparam logic [ADDR_W-1:0] A_CTRL     = ADDR_W'(ADDR_CTRL);
  localparam logic [ADDR_W-1:0] A_STAT     = ADDR_W'(ADDR_STAT);

  logic     time_sel, time_wr, step;
  logic     run, view, snap;
  logic     ev_s, ev_m, ev_h, ev_d;
  logic [7:0] ctrl_v, stat_v;
  tk_time_t live, shadow;

  assign time_sel = (addr_i < A_TIME_END);
  assign time_wr  = wr_i & time_sel;
  assign step     = tick_i & run & ~time_wr;

  tk_calendar u_cal (
    .clk       (clk),
    .rst_n     (rst_n),
    .step_i    (step),
    .ld_en_i   (time_wr),
    .ld_idx_i  (addr_i[2:0]),
    .ld_data_i (wdata_i),
    .now_o     (live),
    .ev_sec_o  (ev_s),
    .ev_min_o  (ev_m),
    .ev_hour_o (ev_h),
    .ev_day_o  (ev_d)
  );

  tk_shadow u_shadow (
    .clk    (clk),
    .rst_n  (rst_n),
    .snap_i (snap),
    .live_i (live),
    .held_o (shadow)
  );

  tk_ctrl_status u_cs (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_ctrl_i (wr_i && (addr_i == A_CTRL)),
    .wr_stat_i (wr_i && (addr_i == A_STAT)),
    .wdata_i   (wdata_i),
    .ev_sec_i  (ev_s),
    .ev_min_i  (ev_m),
    .ev_hour_i (ev_h),
    .ev_day_i  (ev_d),
    .ctrl_o    (ctrl_v),
    .stat_o    (stat_v),
    .run_o     (run),
    .view_o    (view),
    .snap_o    (snap)
  );

  always_comb begin
    if (time_sel)              rdata_o = view ? pick_field(shadow, addr_i[2:0])
                                              : pick_field(live, addr_i[2:0]);
    else if (addr_i == A_CTRL) rdata_o = ctrl_v;
    else if (addr_i == A_STAT) rdata_o = stat_v;
    else                       rdata_o = 8'h00;
  end

  assign ev_sec_o  = ev_s;
  assign ev_min_o  = ev_m;
  assign ev_hour_o = ev_h;
  assign ev_day_o  = ev_d;

  assert_halt_freezes_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !time_wr) |=> ($stable(live) && !ev_sec_o));

  assert_tick_dropped_on_load_R7: assert property (@(posedge clk) disable iff (!rst_n)
    time_wr |=> !ev_sec_o);

  assert_status_run_mirror_R2: assert property (@(posedge clk) disable iff (!rst_n)
    stat_v[SB_RUN] == ctrl_v[CB_RUN]);

endmodule

// File: tb/sim_bcd_timekeeper.sv
`timescale 1ns/1ps
module sim_bcd_timekeeper;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b0;
  logic       wr = 1'b0;
  logic [4:0] addr = 5'd0;
  logic [7:0] wdata = 8'h00;
  logic [7:0] rdata;
  logic       ev_s, ev_m, ev_h, ev_d;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  int ms, mm, mh, md, mmo, my, mwd;

  always #2.5 clk = ~clk;

  bcd_timekeeper #(.ADDR_W(5)) u0 (
    .clk(clk), .rst_n(rst_n), .tick_i(tick), .addr_i(addr), .wdata_i(wdata),
    .wr_i(wr), .rdata_o(rdata), .ev_sec_o(ev_s), .ev_min_o(ev_m),
    .ev_hour_o(ev_h), .ev_day_o(ev_d)
  );

  function automatic logic [7:0] to_bcd(int v);
    return 8'(((v / 10) << 4) | (v % 10));
  endfunction

  function automatic int mlen(int mo, int y);
    if (mo == 2) return (y % 4 == 0) ? 29 : 28;
    if (mo == 4 || mo == 6 || mo == 9 || mo == 11) return 30;
    return 31;
  endfunction

  task automatic chk(string req, string what, logic [7:0] got, logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, got, exp);
    end
  endtask

  task automatic wr_reg(int a, logic [7:0] d);
    @(negedge clk);
    addr = 5'(a); wdata = d; wr = 1'b1;
    @(negedge clk);
    wr = 1'b0;
  endtask

  task automatic rd_reg(int a, output logic [7:0] v);
    @(negedge clk);
    addr = 5'(a);
    #1;
    v = rdata;
  endtask

  task automatic check_fields(string req, int n);
    logic [7:0] v;
    int exp [7];
    exp = '{ms, mm, mh, md, mmo, my, mwd};
    for (int i = 0; i < n; i++) begin
      rd_reg(i, v);
      chk(req, $sformatf("field%0d", i), v, to_bcd(exp[i]));
    end
  endtask

  task automatic model_tick(output bit es, output bit em, output bit eh, output bit ed);
    es = 1; em = 0; eh = 0; ed = 0;
    ms++;
    if (ms == 60) begin
      ms = 0; mm++; em = 1;
      if (mm == 60) begin
        mm = 0; mh++; eh = 1;
        if (mh == 24) begin
          mh = 0; ed = 1; mwd = (mwd + 1) % 7; md++;
          if (md > mlen(mmo, my)) begin
            md = 1; mmo++;
            if (mmo == 13) begin mmo = 1; my = (my + 1) % 100; end
          end
        end
      end
    end
  endtask

  task automatic do_tick(string req);
    bit es, em, eh, ed;
    @(negedge clk); tick = 1'b1;
    @(negedge clk); tick = 1'b0;
    model_tick(es, em, eh, ed);
    chk(req, "ev_sec",  {7'b0, ev_s}, {7'b0, es});
    chk(req, "ev_min",  {7'b0, ev_m}, {7'b0, em});
    chk(req, "ev_hour", {7'b0, ev_h}, {7'b0, eh});
    chk(req, "ev_day",  {7'b0, ev_d}, {7'b0, ed});
  endtask

  task automatic set_time(int h, int m, int s, int d, int mo, int y, int wd);
    wr_reg(13, 8'h00);
    wr_reg(0, to_bcd(s)); wr_reg(1, to_bcd(m)); wr_reg(2, to_bcd(h));
    wr_reg(3, to_bcd(d)); wr_reg(4, to_bcd(mo)); wr_reg(5, to_bcd(y));
    wr_reg(6, to_bcd(wd));
    wr_reg(13, 8'h01);
    ms = s; mm = m; mh = h; md = d; mmo = mo; my = y; mwd = wd;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog all-requirements actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    int yrs [5];
    int sv [7];

    ms = 0; mm = 0; mh = 0; md = 1; mmo = 1; my = 0; mwd = 0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    check_fields("R1", 7);
    rd_reg(13, v); chk("R1", "ctrl", v, 8'h00);
    rd_reg(14, v); chk("R1", "status", v, 8'h80);
    // R11 unmapped address
    rd_reg(15, v); chk("R11", "unmapped", v, 8'h00);

    // R2 halted: ticks do nothing
    for (int k = 0; k < 5; k++) begin
      @(negedge clk); tick = 1'b1;
      @(negedge clk); tick = 1'b0;
      chk("R2", "ev_sec halted", {7'b0, ev_s}, 8'h00);
    end
    check_fields("R2", 7);
    rd_reg(14, v); chk("R2", "status run=0", v, 8'h80);
    wr_reg(13, 8'h01);
    rd_reg(14, v); chk("R2", "status run=1", v, 8'h82);

    // R3 / R6 one hour of ticks from midnight
    for (int k = 0; k < 3600; k++) begin
      do_tick("R6");
      check_fields("R3", 3);
    end
    check_fields("R3", 7);

    // R4 / R5 month-end sweep over a leap cycle and the century wrap
    yrs = '{0, 1, 2, 3, 99};
    foreach (yrs[yi]) begin
      for (int mo = 1; mo <= 12; mo++) begin
        set_time(23, 59, 59, mlen(mo, yrs[yi]) - 1, mo, yrs[yi], mo % 7);
        do_tick("R4");
        check_fields("R4", 7);
        set_time(23, 59, 59, mlen(mo, yrs[yi]), mo, yrs[yi], 6);
        do_tick("R4");
        check_fields("R5", 7);
      end
    end

    // R5 weekday across eight midnights
    set_time(23, 59, 59, 5, 3, 10, 0);
    for (int k = 0; k < 8; k++) begin
      do_tick("R5");
      rd_reg(6, v); chk("R5", "weekday", v, to_bcd(mwd));
      wr_reg(2, 8'h23); wr_reg(1, 8'h59); wr_reg(0, 8'h59);
      mh = 23; mm = 59; ms = 59;
    end

    // R7 load in the same cycle as a tick
    set_time(8, 15, 40, 12, 7, 21, 2);
    @(negedge clk); tick = 1'b1; addr = 5'd1; wdata = 8'h33; wr = 1'b1;
    @(negedge clk); tick = 1'b0; wr = 1'b0;
    chk("R7", "ev_sec dropped", {7'b0, ev_s}, 8'h00);
    mm = 33;
    check_fields("R7", 7);

    // R8 / R9 snapshot and shadow view
    set_time(10, 20, 30, 14, 2, 24, 3);
    wr_reg(13, 8'h41);
    sv = '{ms, mm, mh, md, mmo, my, mwd};
    do_tick("R9"); do_tick("R9"); do_tick("R9");
    wr_reg(13, 8'h81);
    for (int i = 0; i < 7; i++) begin
      rd_reg(i, v); chk("R9", $sformatf("shadow%0d", i), v, to_bcd(sv[i]));
    end
    rd_reg(13, v); chk("R8", "ctrl readback", v, 8'h81);
    wr_reg(13, 8'hC1);
    check_fields("R8", 7);
    rd_reg(13, v); chk("R8", "snap bit reads 0", v, 8'h81);
    do_tick("R9");
    rd_reg(0, v); chk("R9", "shadow sec held", v, to_bcd(33));
    wr_reg(13, 8'h01);
    check_fields("R9", 7);

    // R10 status sticky bits, clear, set-wins
    wr_reg(14, 8'hFF);
    rd_reg(14, v); chk("R10", "cleared incl power-up", v, 8'h02);
    set_time(23, 59, 59, 1, 1, 5, 0);
    do_tick("R10");
    rd_reg(14, v); chk("R10", "all events sticky", v, 8'h3E);
    @(negedge clk); tick = 1'b1;
    @(negedge clk); tick = 1'b0; addr = 5'd14; wdata = 8'h04; wr = 1'b1;
    begin
      bit es, em, eh, ed;
      model_tick(es, em, eh, ed);
    end
    @(negedge clk); wr = 1'b0;
    rd_reg(14, v); chk("R10", "event wins over clear", v, 8'h3E);
    wr_reg(14, 8'h04);
    rd_reg(14, v); chk("R10", "clear sec bit", v, 8'h3A);

    // R11 stored control bits have no effect; 24-hour counting
    set_time(12, 59, 59, 9, 9, 9, 1);
    wr_reg(13, 8'h3F);
    rd_reg(13, v); chk("R11", "ctrl readback", v, 8'h3F);
    do_tick("R11");
    check_fields("R11", 7);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule